// File: doc/BRIEF.md
# Flash Security Register Controller

This block holds the security state of a serial flash command slave. It is driven by the opcode decoder of the surrounding device: one strobe per opcode byte, a strobe when chip select rises with a flag that tells whether the rise landed on a whole byte, a busy level while the program/erase engine is working, and one-cycle fail pulses from that engine. It keeps a small security register and a mode flag for the one-time-programmable (OTP) area.

The register holds a factory-lock bit taken from a tie-off input, a customer lock-down bit, a program-fail flag, an erase-fail flag and a protection-select bit. The lock-down bit can only be set. Once set it stays set until reset, and it freezes the OTP area against writes. While OTP mode is entered, requests to the main array are refused. The array, the serial shifter and the ID reads are outside the block.

Top module: `secreg_ctrl`

## Requirements
- R1: After reset, otp_mode is 0, rd_active is 0, and secreg holds only the factory-lock bit (bit 0 = factory_lock). All other bits are 0.
- R2: Opcode B1h sets otp_mode and opcode C1h clears it. The new value is visible in the cycle after the opcode strobe.
- R3: While busy is high, both OTP-mode opcodes (B1h and C1h) are ignored.
- R4: array_grant equals array_req AND NOT otp_mode, with no added cycle.
- R5: Opcode 2Fh, followed by a chip-select rise with cs_on_boundary high while busy is low, sets the lock-down bit (bit 1). This bit then stays 1 until reset.
- R6: Opcode 2Fh is discarded in three cases: chip select rises off a byte boundary, busy is high at the rise, or another opcode strobe comes before the rise.
- R7: A pgm_fail_pulse sets bit 2 and an ers_fail_pulse sets bit 3. Each flag holds until opcode 30h clears both. A fail pulse in the same cycle as 30h leaves its own flag set.
- R8: otp_wr_grant equals otp_wr_req AND otp_mode AND NOT lock-down.
- R9: Opcode 68h, completed like R5, sets the protection-select bit (bit 4). The bit cannot be cleared before reset.
- R10: rd_active rises in the cycle after opcode 2Bh. It falls after a chip-select rise or after any other opcode strobe.
- R11: secreg bits 7 to 5 always read 0, and bit 0 always follows factory_lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Opcode byte strobe |
| cmd_byte | input | 8 | Decoded opcode |
| cs_rise | input | 1 | Chip select deasserted this cycle |
| cs_on_boundary | input | 1 | The chip-select rise landed on a whole byte |
| busy | input | 1 | Program or erase in progress |
| pgm_fail_pulse | input | 1 | Program failure, one cycle |
| ers_fail_pulse | input | 1 | Erase failure, one cycle |
| factory_lock | input | 1 | Factory lock tie-off |
| array_req | input | 1 | Main array access request |
| otp_wr_req | input | 1 | OTP area write request |
| array_grant | output | 1 | Main array access allowed |
| otp_wr_grant | output | 1 | OTP write allowed |
| otp_mode | output | 1 | OTP mode entered |
| rd_active | output | 1 | Security register read in progress |
| secreg | output | 8 | Security register value |

## Verification
The bench goes after a lock-down opcode whose chip-select rise is off a byte boundary, arrives during busy, or follows an intervening opcode. A design that arms on the opcode alone would lock the OTP area by accident. It also drives a fail pulse in the same cycle as the clear opcode; a design where the clear wins would lose a real failure. It tries OTP-mode opcodes during busy, which a careless design would honour and so block the array in the middle of an operation. Random traffic then checks that lock-down and protection-select never fall back to 0.

// File: rtl/secreg_pkg.sv
package secreg_pkg;
   localparam int unsigned BIT_FACTORY = 0;
   localparam int unsigned BIT_LOCK    = 1;
   localparam int unsigned BIT_PFAIL   = 2;
   localparam int unsigned BIT_EFAIL   = 3;
   localparam int unsigned BIT_PSEL    = 4;
   localparam int unsigned USED_BITS   = 5;
   localparam int unsigned NUM_FAIL    = 2;

   typedef struct packed {
      logic enter_otp;
      logic exit_otp;
      logic clr_fail;
      logic set_lock;
      logic set_psel;
   } sec_act_t;
endpackage

// File: rtl/secreg_cmd_decode.sv
module secreg_cmd_decode
   import secreg_pkg::*;
#(
   parameter int unsigned OP_W       = 8,
   parameter logic [OP_W-1:0] OP_RD   = 8'h2B,
   parameter logic [OP_W-1:0] OP_LOCK = 8'h2F,
   parameter logic [OP_W-1:0] OP_CLR  = 8'h30,
   parameter logic [OP_W-1:0] OP_ENT  = 8'hB1,
   parameter logic [OP_W-1:0] OP_EXT  = 8'hC1,
   parameter logic [OP_W-1:0] OP_PSEL = 8'h68
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   input  logic [OP_W-1:0] cmd_byte,
   input  logic            cs_rise,
   input  logic            cs_on_boundary,
   input  logic            busy,
   output sec_act_t        act,
   output logic            rd_active
);
   logic            pend_q;
   logic [OP_W-1:0] pend_op_q;
   logic            commit;

   assign commit = cs_rise && pend_q && cs_on_boundary && !busy;

   always_comb begin
      act.enter_otp = cmd_valid && !busy && (cmd_byte == OP_ENT);
      act.exit_otp  = cmd_valid && !busy && (cmd_byte == OP_EXT);
      act.clr_fail  = cmd_valid && (cmd_byte == OP_CLR);
      act.set_lock  = commit && (pend_op_q == OP_LOCK);
      act.set_psel  = commit && (pend_op_q == OP_PSEL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         pend_op_q <= '0;
         rd_active <= 1'b0;
      end else if (cs_rise) begin
         pend_q    <= 1'b0;
         rd_active <= 1'b0;
      end else if (cmd_valid) begin
         pend_q    <= (cmd_byte == OP_LOCK) || (cmd_byte == OP_PSEL);
         pend_op_q <= cmd_byte;
         rd_active <= (cmd_byte == OP_RD);
      end
   end
endmodule

// File: rtl/secreg_state.sv
module secreg_state
   import secreg_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  sec_act_t         act,
   input  logic [NUM_FAIL-1:0] fail_pulse,
   input  logic             factory_lock,
   output logic             otp_mode,
   output logic             locked,
   output logic [REG_W-1:0] secreg
);
   logic                psel_q;
   logic [NUM_FAIL-1:0] fail_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         otp_mode <= 1'b0;
         locked   <= 1'b0;
         psel_q   <= 1'b0;
      end else begin
         if (act.enter_otp)      otp_mode <= 1'b1;
         else if (act.exit_otp)  otp_mode <= 1'b0;
         if (act.set_lock)       locked   <= 1'b1;
         if (act.set_psel)       psel_q   <= 1'b1;
      end
   end

   for (genvar g = 0; g < NUM_FAIL; g++) begin : g_fail
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              fail_q[g] <= 1'b0;
         else if (fail_pulse[g])  fail_q[g] <= 1'b1;
         else if (act.clr_fail)   fail_q[g] <= 1'b0;
      end
   end

   always_comb begin
      secreg              = '0;
      secreg[BIT_FACTORY] = factory_lock;
      secreg[BIT_LOCK]    = locked;
      secreg[BIT_PFAIL]   = fail_q[0];
      secreg[BIT_EFAIL]   = fail_q[1];
      secreg[BIT_PSEL]    = psel_q;
   end
endmodule

// File: rtl/secreg_access_gate.sv
module secreg_access_gate (
   input  logic array_req,
   input  logic otp_wr_req,
   input  logic otp_mode,
   input  logic locked,
   output logic array_grant,
   output logic otp_wr_grant
);
   assign array_grant  = array_req && !otp_mode;
   assign otp_wr_grant = otp_wr_req && otp_mode && !locked;
endmodule

// File: rtl/secreg_ctrl.sv
module secreg_ctrl
   import secreg_pkg::*;
#(
   parameter int unsigned OP_W  = 8,
   parameter int unsigned REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [OP_W-1:0]  cmd_byte,
   input  logic             cs_rise,
   input  logic             cs_on_boundary,
   input  logic             busy,
   input  logic             pgm_fail_pulse,
   input  logic             ers_fail_pulse,
   input  logic             factory_lock,
   input  logic             array_req,
   input  logic             otp_wr_req,
   output logic             array_grant,
   output logic             otp_wr_grant,
   output logic             otp_mode,
   output logic             rd_active,
   output logic [REG_W-1:0] secreg
);
   if (REG_W < USED_BITS) begin : g_bad_reg_w
      $error("secreg_ctrl: REG_W too small for the register fields");
   end
   if (OP_W != 8) begin : g_bad_op_w
      $error("secreg_ctrl: opcodes are one byte wide");
   end

   sec_act_t act;
   logic     locked;

   secreg_cmd_decode #(.OP_W(OP_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .cs_rise(cs_rise), .cs_on_boundary(cs_on_boundary), .busy(busy),
      .act(act), .rd_active(rd_active)
   );

   secreg_state #(.REG_W(REG_W)) u_state (
      .clk(clk), .rst_n(rst_n), .act(act),
      .fail_pulse({ers_fail_pulse, pgm_fail_pulse}),
      .factory_lock(factory_lock), .otp_mode(otp_mode),
      .locked(locked), .secreg(secreg)
   );

   secreg_access_gate u_gate (
      .array_req(array_req), .otp_wr_req(otp_wr_req), .otp_mode(otp_mode),
      .locked(locked), .array_grant(array_grant), .otp_wr_grant(otp_wr_grant)
   );
endmodule

// File: rtl/secreg_ctrl_chk.sv
module secreg_ctrl_chk #(
   parameter int unsigned REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             pgm_fail_pulse,
   input logic             ers_fail_pulse,
   input logic             factory_lock,
   input logic             array_req,
   input logic             array_grant,
   input logic             otp_wr_grant,
   input logic             otp_mode,
   input logic [REG_W-1:0] secreg
);
   assert_array_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
      array_grant |-> (array_req && !otp_mode));
   assert_array_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (array_req && !otp_mode) |-> array_grant);
   assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(otp_mode));
   assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      secreg[1] |=> secreg[1]);
   assert_psel_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      secreg[4] |=> secreg[4]);
   assert_pfail_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_fail_pulse |=> secreg[2]);
   assert_efail_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ers_fail_pulse |=> secreg[3]);
   assert_otp_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      otp_wr_grant |-> (otp_mode && !secreg[1]));
   assert_layout_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((secreg >> 5) == '0) && (secreg[0] == factory_lock));
endmodule

bind secreg_ctrl secreg_ctrl_chk #(.REG_W(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .pgm_fail_pulse(pgm_fail_pulse),
   .ers_fail_pulse(ers_fail_pulse), .factory_lock(factory_lock),
   .array_req(array_req), .array_grant(array_grant),
   .otp_wr_grant(otp_wr_grant), .otp_mode(otp_mode), .secreg(secreg)
);

// File: tb/test_secreg_ctrl.sv
module test_secreg_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_byte = 8'h00;
   logic       cs_rise = 1'b0, cs_on_boundary = 1'b0, busy = 1'b0;
   logic       pgm_fail_pulse = 1'b0, ers_fail_pulse = 1'b0;
   logic       factory_lock = 1'b1, array_req = 1'b0, otp_wr_req = 1'b0;
   logic       array_grant, otp_wr_grant, otp_mode, rd_active;
   logic [7:0] secreg;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // bench model
   bit m_otp, m_lock, m_psel, m_pf, m_ef, m_rd, m_pend;
   logic [7:0] m_pop;

   always #10 clk = ~clk;

   secreg_ctrl i_secreg_ctrl (.*);

   function automatic logic [7:0] exp_reg();
      return {3'b000, m_psel, m_ef, m_pf, m_lock, factory_lock};
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_step();
      bit commit;
      commit = cs_rise && m_pend && cs_on_boundary && !busy;
      if (cmd_valid && !busy && cmd_byte == 8'hB1) m_otp = 1;
      else if (cmd_valid && !busy && cmd_byte == 8'hC1) m_otp = 0;
      if (commit && m_pop == 8'h2F) m_lock = 1;
      if (commit && m_pop == 8'h68) m_psel = 1;
      if (pgm_fail_pulse) m_pf = 1; else if (cmd_valid && cmd_byte == 8'h30) m_pf = 0;
      if (ers_fail_pulse) m_ef = 1; else if (cmd_valid && cmd_byte == 8'h30) m_ef = 0;
      if (cs_rise) begin m_pend = 0; m_rd = 0; end
      else if (cmd_valid) begin
         m_pend = (cmd_byte == 8'h2F) || (cmd_byte == 8'h68);
         m_pop  = cmd_byte;
         m_rd   = (cmd_byte == 8'h2B);
      end
   endtask

   // one cycle: drive at negedge, check combinational, advance, check state
   task automatic cyc(string req);
      #1;
      chk({req, "/R4 grant"}, {7'd0, array_grant}, {7'd0, array_req && !m_otp});
      chk({req, "/R8 otp_wr"}, {7'd0, otp_wr_grant}, {7'd0, otp_wr_req && m_otp && !m_lock});
      model_step();
      @(negedge clk);
      cmd_valid = 0; cs_rise = 0; pgm_fail_pulse = 0; ers_fail_pulse = 0;
      chk({req, " reg"}, secreg, exp_reg());
      chk({req, " otp"}, {7'd0, otp_mode}, {7'd0, m_otp});
      chk({req, "/R10 rd"}, {7'd0, rd_active}, {7'd0, m_rd});
   endtask

   task automatic op(logic [7:0] c, string req);
      cmd_valid = 1; cmd_byte = c; cyc(req);
   endtask

   task automatic rise(bit bnd, string req);
      cs_rise = 1; cs_on_boundary = bnd; cyc(req);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1 reset reg", secreg, 8'h01);
      chk("R1 reset otp", {7'd0, otp_mode}, 8'h00);
      chk("R1 reset rd", {7'd0, rd_active}, 8'h00);
      rst_n = 1;
      @(negedge clk);
      // R2 enter / exit
      op(8'hB1, "R2 enter");
      array_req = 1; otp_wr_req = 1; cyc("R4 blocked in otp");
      op(8'hC1, "R2 exit");
      // R3 busy blocks
      busy = 1; op(8'hB1, "R3 enter busy"); busy = 0;
      op(8'hB1, "R2 enter again");
      busy = 1; op(8'hC1, "R3 exit busy"); busy = 0;
      // R6 lock discarded off boundary, busy, intervening opcode
      op(8'h2F, "R6 lock"); rise(0, "R6 off boundary");
      op(8'h2F, "R6 lock"); busy = 1; rise(1, "R6 busy at rise"); busy = 0;
      op(8'h2F, "R6 lock"); op(8'h05, "R6 other"); rise(1, "R6 intervened");
      chk("R6 still unlocked", secreg, 8'h01);
      // R10 read
      op(8'h2B, "R10 read"); cyc("R10 read hold"); rise(1, "R10 read end");
      // R7 fail flags and clear race
      pgm_fail_pulse = 1; cyc("R7 pfail");
      ers_fail_pulse = 1; cyc("R7 efail");
      op(8'h30, "R7 clear");
      pgm_fail_pulse = 1; op(8'h30, "R7 pulse beats clear");
      // R9 protection select
      op(8'h68, "R9 psel"); rise(1, "R9 psel commit");
      // R5 lock, then R8 otp writes refused
      op(8'h2F, "R5 lock"); rise(1, "R5 lock commit");
      chk("R5 locked", secreg & 8'h02, 8'h02);
      cyc("R8 otp write after lock");
      factory_lock = 0; cyc("R11 factory follows");
      // random traffic
      for (int i = 0; i < 4000; i++) begin
         int k;
         k = $urandom_range(0, 7);
         if ($urandom_range(0, 3) == 0) begin
            cs_rise = 1; cs_on_boundary = ($urandom_range(0, 3) != 0);
         end else if ($urandom_range(0, 1) == 0) begin
            cmd_valid = 1;
            case (k)
               0: cmd_byte = 8'h2B; 1: cmd_byte = 8'h2F; 2: cmd_byte = 8'h30;
               3: cmd_byte = 8'hB1; 4: cmd_byte = 8'hC1; 5: cmd_byte = 8'h68;
               default: cmd_byte = 8'($urandom);
            endcase
         end
         busy = ($urandom_range(0, 3) == 0);
         pgm_fail_pulse = ($urandom_range(0, 15) == 0);
         ers_fail_pulse = ($urandom_range(0, 15) == 0);
         array_req = $urandom_range(0, 1);
         otp_wr_req = $urandom_range(0, 1);
         factory_lock = $urandom_range(0, 1);
         if (i == 2000) begin
            // early random phase done: re-run from reset so lock starts clear
            rst_n = 0; @(negedge clk); rst_n = 1;
            m_otp = 0; m_lock = 0; m_psel = 0; m_pf = 0; m_ef = 0; m_rd = 0; m_pend = 0;
            cmd_valid = 0; cs_rise = 0;
            chk("R1 reset again", secreg, {7'd0, factory_lock});
         end
         cyc("R2-random");
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule